// File: doc/BRIEF.md
# Carry-completion-detecting ripple adder

This block adds two unsigned or two's-complement operands and a carry-in. It does not wait a fixed worst-case number of cycles. It finishes as soon as every carry in the word is known. Each bit position holds its outgoing carry as a two-rail code, with one rail meaning "known one" and the other meaning "known zero". A position whose operand bits generate or kill a carry knows its carry at once. A position that only propagates copies the known state of the position below it, one position per clock cycle.

The user pulses `start` with the operands on the inputs. The block then raises `done` once no position remains unresolved. It reports the sum, the carry-out, the signed overflow flag, and the number of cycles the addition took. The latency depends on the data: it is the longest run of propagating bit positions plus one.

Top module: `settle_adder`

## Requirements
- R1: After reset, `done` is 0 and `cycles` is 0.
- R2: For each bit of the operands, `x AND y` generates a carry, `x XOR y` propagates one, and `NOR(x, y)` kills one. Exactly one of the three holds.
- R3: Each position's carry state is a two-bit code. In this code, 2'b10 means a known one, 2'b01 means a known zero and 2'b00 means unresolved. The code 2'b11 never appears.
- R4: On an accepted start, generating positions become a known one and killing positions become a known zero in the same clock edge. Propagating positions become unresolved.
- R5: On each following clock edge, an unresolved position takes the state of the position below it if that state is resolved. Bit 0 takes the latched carry-in. A resolved state does not change until the next accepted start.
- R6: `done` is high exactly when a run has been started and no position is unresolved. It stays high until the next accepted start.
- R7: While `done` is high, `{carry_out, sum_out}` equals the operand A plus operand B plus the carry-in of the accepted start.
- R8: While `done` is high, `cycles` equals the longest run of consecutive propagating bits plus one. This count includes the start edge, so its range is 1 to WIDTH+1.
- R9: A `start` pulse that arrives while a run is in progress and `done` is low is ignored. The result of the running addition is unchanged.
- R10: While `done` is high, `overflow` equals the carry out of the top bit XOR the carry into the top bit.
- R11: A `start` pulse that arrives while `done` is high is accepted on that edge and begins a new addition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an addition with the present operands |
| a_in | input | WIDTH | Operand A |
| b_in | input | WIDTH | Operand B |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH | Sum, valid while done is high |
| carry_out | output | 1 | Carry out of the top bit |
| overflow | output | 1 | Signed overflow |
| done | output | 1 | All carries resolved |
| cycles | output | $clog2(WIDTH+2) | Cycles taken by the last addition |

## Verification
Some properties are checked on every cycle:
- the two-rail code never takes its illegal value;
- resolved carries stay put;
- the operand classification is one-hot at load;
- the sum and overflow are arithmetically right whenever `done` is high;
- the cycle counter rises by one per unresolved cycle;
- the latched operands cannot change during a run.

The bench's scenarios are needed for the rest. The data-dependent latency, that is, that it matches the longest propagate run for every operand pair, can only be shown by counting edges from start. The same holds for dropping a start during a run and for accepting a back-to-back start after `done`.

// File: rtl/settle_pkg.sv
package settle_pkg;
  typedef logic [1:0] rail_t;
  localparam rail_t RAIL_NONE = 2'b00;
  localparam rail_t RAIL_ONE  = 2'b10;
  localparam rail_t RAIL_ZERO = 2'b01;

  typedef struct packed {
    logic gen;
    logic prop;
    logic kill;
  } bitclass_t;

  function automatic bitclass_t classify(input logic x, input logic y);
    bitclass_t c;
    c.gen  = x & y;
    c.prop = x ^ y;
    c.kill = ~(x | y);
    return c;
  endfunction

  function automatic rail_t seed_rail(input bitclass_t c);
    if (c.gen)       return RAIL_ONE;
    else if (c.kill) return RAIL_ZERO;
    else             return RAIL_NONE;
  endfunction

  function automatic logic is_known(input rail_t r);
    return r != RAIL_NONE;
  endfunction

  function automatic rail_t rail_of(input logic b);
    return b ? RAIL_ONE : RAIL_ZERO;
  endfunction
endpackage

// File: rtl/settle_cell.sv
module settle_cell
  import settle_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  logic      step,
  input  bitclass_t cls,
  input  rail_t     below,
  output rail_t     state
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      state <= RAIL_NONE;
    else if (load)
      state <= seed_rail(cls);
    else if (step && !is_known(state) && is_known(below))
      state <= below;
  end

  // R3
  rail_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state != 2'b11);

  // R5
  rail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_known(state) && !load) |=> $stable(state));

  // R2
  class_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> $onehot(cls));
endmodule

// File: rtl/settle_ctrl.sv
module settle_ctrl #(
  parameter int CW   = 4,
  parameter int MAXC = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          all_known,
  output logic          load,
  output logic          step,
  output logic          run,
  output logic          done,
  output logic [CW-1:0] count
);
  assign done = run & all_known;
  assign load = start & (~run | all_known);
  assign step = run & ~all_known;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run   <= 1'b0;
      count <= '0;
    end else if (load) begin
      run   <= 1'b1;
      count <= CW'(1);
    end else if (step) begin
      count <= count + CW'(1);
    end
  end

  // R8
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (count >= CW'(1) && count <= CW'(MAXC)));

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !all_known && !start) |=> count == $past(count) + CW'(1));

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

// File: rtl/settle_adder.sv
module settle_adder
  import settle_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int CW   = $clog2(WIDTH + 2),
  localparam int MAXC = WIDTH + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out,
  output logic             overflow,
  output logic             done,
  output logic [CW-1:0]    cycles
);
  logic [WIDTH-1:0] a_q, b_q, known_v, cin_v;
  logic             cin_q, load, step, run, all_known;
  rail_t            st    [WIDTH];
  rail_t            below [WIDTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      cin_q <= 1'b0;
    end else if (load) begin
      a_q   <= a_in;
      b_q   <= b_in;
      cin_q <= carry_in;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign below[i] = rail_of(cin_q);
      assign cin_v[i] = cin_q;
    end else begin : g_upper
      assign below[i] = st[i-1];
      assign cin_v[i] = st[i-1][1];
    end
    assign known_v[i] = is_known(st[i]);

    settle_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .step  (step),
      .cls   (classify(a_in[i], b_in[i])),
      .below (below[i]),
      .state (st[i])
    );
  end

  assign all_known = &known_v;

  settle_ctrl #(.CW(CW), .MAXC(MAXC)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .all_known (all_known),
    .load      (load),
    .step      (step),
    .run       (run),
    .done      (done),
    .count     (cycles)
  );

  assign sum_out   = (a_q ^ b_q) ^ cin_v;
  assign carry_out = st[WIDTH-1][1];
  assign overflow  = carry_out ^ cin_v[WIDTH-1];

  // R7
  sum_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> {carry_out, sum_out} ==
      ({1'b0, a_q} + {1'b0, b_q} + (WIDTH+1)'(cin_q)));

  // R10
  ovf_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> overflow ==
      ((a_q[WIDTH-1] == b_q[WIDTH-1]) && (sum_out[WIDTH-1] != a_q[WIDTH-1])));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !done) |=> ($stable(a_q) && $stable(b_q) && $stable(cin_q)));
endmodule

// File: tb/test_settle_adder.sv
module test_settle_adder;
  localparam int W  = 4;
  localparam int CW = $clog2(W + 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic carry_in = 1'b0;
  logic [W-1:0] sum_out;
  logic carry_out, overflow, done;
  logic [CW-1:0] cycles;
  int n_checks = 0, n_fail = 0;
  bit wd_hit = 0;

  always #5 clk = ~clk;

  settle_adder #(.WIDTH(W)) i_settle_adder (
    .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
    .carry_in(carry_in), .sum_out(sum_out), .carry_out(carry_out),
    .overflow(overflow), .done(done), .cycles(cycles));

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int longest_run(input logic [W-1:0] p);
    int best = 0, cur = 0;
    for (int i = 0; i < W; i++) begin
      cur  = p[i] ? cur + 1 : 0;
      best = (cur > best) ? cur : best;
    end
    return best;
  endfunction

  // Drives one addition, counts edges until done, then checks the result.
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic ci, input bit poke);
    int edges, total, lr;
    logic ovf_exp;
    @(negedge clk);
    a_in = a; b_in = b; carry_in = ci; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    edges = 1;
    while (!done && edges < 40) begin
      if (poke && edges == 1) begin
        @(negedge clk);
        a_in = ~a; b_in = ~b; carry_in = ~ci; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
      end else begin
        @(posedge clk); #1;
      end
      edges++;
    end
    if (!done) begin
      check("R6 done timeout", 0, 1);
      return;
    end
    total   = int'(a) + int'(b) + int'(ci);
    lr      = longest_run(a ^ b);
    ovf_exp = (a[W-1] == b[W-1]) && (total[W-1] != a[W-1]);
    check("R7 sum", int'({carry_out, sum_out}), total);
    check("R8 cycles", int'(cycles), lr + 1);
    check("R4/R5 latency edges", edges, lr + 1);
    check("R10 overflow", int'(overflow), int'(ovf_exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    wd_hit = 1;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 done", int'(done), 0);
    check("R1 cycles", int'(cycles), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R4 R5 R7 R8 R10: exhaustive sweep over all operand pairs
    for (int a = 0; a < (1 << W) && !wd_hit; a++)
      for (int b = 0; b < (1 << W); b++)
        for (int c = 0; c < 2; c++)
          run_op(W'(a), W'(b), 1'(c), 1'b0);

    // R9 start during a full-length propagate run is ignored
    run_op(4'b1111, 4'b0000, 1'b1, 1'b1);
    // R9 another ignored start from a mid-length run
    run_op(4'b0110, 4'b0011, 1'b0, 1'b1);

    // R11 start while done high is accepted: done drops next sample
    @(negedge clk);
    check("R6 done held", int'(done), 1);
    a_in = 4'b0101; b_in = 4'b1010; carry_in = 1'b1; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    check("R11 accepted start clears done", int'(done), 0);
    check("R11 cycles restart", int'(cycles), 1);
    repeat (6) @(posedge clk);
    #1;
    check("R11 new sum", int'({carry_out, sum_out}), 16);
    check("R6 done after run", int'(done), 1);

    if (wd_hit) check("watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule